// File: doc/BRIEF.md
# Staged Clock Configuration Register Bank

This block is the software-facing register file of a root clock generator. A small register bus (word-aligned byte address, write strobe, write data, combinational read data) reaches five registers: a command register, a configuration register that holds the pre-divider, source select and counter mode, and three fractional-counter registers (M, N, D). Writes to the configuration and counter registers land in shadow copies. The outputs that drive the divider and the source multiplexer come only from the active copies, so a half-written setup never reaches the clock path.

Software requests a switch by setting the update bit in the command register. The bank then waits for a one-cycle safe-switch pulse from the clock datapath and copies every shadow register into its active copy on a single edge. On that edge the update bit and all dirty flags clear. Software polls the update bit until it reads zero. A commit is never held off for long: if no safe pulse arrives within `MAX_WAIT` cycles of a pending request, the commit is forced. The command register also carries a directly written root-enable control and a read-only root-off status taken from the datapath.

Top module: `clkcfg_regbank`

## Requirements
- R1: After reset the active outputs are all zero (source 0, divider bypass, mode 0), `root_en` is 1, and the reads return command = 0x00000002 with `root_off_in` in bit 31, and 0 for configuration, M, N and D.
- R2: A write to the configuration, M, N or D register changes its readback on the next cycle. It leaves the active outputs unchanged until a commit.
- R3: Writing the command register with bit 0 = 1 sets the update bit, which reads back as 1 in bit 0. Writing bit 0 = 0 does not clear a pending update.
- R4: On the first edge where an update is pending and `safe_pulse` is high, all active outputs take their shadow values. On that same edge the update bit and dirty bits 7:4 clear.
- R5: If `safe_pulse` stays low, a pending update commits on the `MAX_WAIT`-th rising edge after the edge that set it.
- R6: Command bits 4, 5, 6 and 7 are the dirty flags of the configuration, N, M and D registers. A flag sets when its register is written with a value that differs from the active value. Writing a value equal to the active value leaves it clear.
- R7: The configuration register holds the divider in bits `DIV_W-1:0`, the source select in bits 10:8 and the mode in bits 13:12. All other bits read as zero and ignore writes.
- R8: M, N and D hold only their low `MND_W` bits. Higher bits read as zero and ignore writes.
- R9: Command bit 1 is the root enable. A write to it reaches `root_en` on the next cycle, without a commit. Bit 31 always reads `root_off_in`, and writes to it have no effect.
- R10: Word offsets 0x14 to 0x1C read as zero, and writes to them change no register. Address bits 1:0 are ignored.
- R11: A `safe_pulse` while no update is pending changes no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| safe_pulse | input | 1 | Datapath signal that a switch is glitch-free this cycle |
| root_off_in | input | 1 | Datapath status, 1 when the output clock is stopped |
| root_en | output | 1 | Root enable to the datapath |
| act_div | output | DIV_W | Active half-integer pre-divider |
| act_src | output | 3 | Active source select |
| act_mode | output | 2 | Active counter mode (2 = dual-edge M/N) |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |

## Verification
The in-RTL assertions check the following on every cycle:
- active registers hold steady except on a commit edge, and copy the shadow exactly when one occurs;
- a commit clears the update bit and the dirty flags;
- an idle safe pulse leaves the bank alone;
- a pending request always resolves within the wait bound.

Only the bench scenarios can show the register-level effects at the bus:
- the bit layout at the bus;
- the upper-bit masking of M, N and D;
- the compare against the active value that decides each dirty flag;
- the exact edge of a forced commit;
- how same-cycle writes and commits interleave under random traffic.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  // word index of each register (byte offset >> 2)
  localparam logic [2:0] W_CMD = 3'd0;
  localparam logic [2:0] W_CFG = 3'd1;
  localparam logic [2:0] W_M   = 3'd2;
  localparam logic [2:0] W_N   = 3'd3;
  localparam logic [2:0] W_D   = 3'd4;

  // command register bit positions
  localparam int CMD_UPD_BIT   = 0;
  localparam int CMD_EN_BIT    = 1;
  localparam int CMD_DCFG_BIT  = 4;
  localparam int CMD_DN_BIT    = 5;
  localparam int CMD_DM_BIT    = 6;
  localparam int CMD_DD_BIT    = 7;
  localparam int CMD_OFF_BIT   = 31;

  // configuration register field positions
  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;
  localparam int SRC_W        = 3;
  localparam int MODE_W       = 2;

  // counter register order inside the bank's generate loop
  typedef enum logic [1:0] {
    CTR_M = 2'd0,
    CTR_N = 2'd1,
    CTR_D = 2'd2
  } ctr_idx_e;
endpackage

// File: rtl/clkcfg_field.sv
module clkcfg_field #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         commit,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] active_q,
  output logic         dirty_q
);
  logic [W-1:0] next_active;

  assign next_active = commit ? shadow_q : active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      dirty_q  <= 1'b0;
    end else begin
      if (commit) begin
        active_q <= shadow_q;
        dirty_q  <= 1'b0;
      end
      if (wr_en) begin
        shadow_q <= wr_val;
        if (wr_val != next_active) dirty_q <= 1'b1;
      end
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q)); // R2
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> active_q == $past(shadow_q)); // R4
  AST_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !wr_en |=> !dirty_q); // R4
endmodule

// File: rtl/clkcfg_commit_ctrl.sv
module clkcfg_commit_ctrl #(
  parameter int MAX_WAIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_set,
  input  logic safe_pulse,
  output logic pending,
  output logic commit
);
  localparam int CW = $clog2(MAX_WAIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT - 1);

  logic [CW-1:0] wait_cnt;

  assign commit = pending && (safe_pulse || wait_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      wait_cnt <= '0;
    end else begin
      if (req_set)     pending <= 1'b1;
      else if (commit) pending <= 1'b0;
      if (commit || !pending) wait_cnt <= '0;
      else                    wait_cnt <= wait_cnt + 1'b1;
    end
  end

  // independent age count used only by the checks below
  logic [CW:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       age <= '0;
    else if (!pending || commit)      age <= '0;
    else                              age <= age + 1'b1;
  end

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !req_set |=> !pending); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !commit |=> pending); // R3
  AST_IDLE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !pending && !req_set |=> !pending); // R11
  AST_BOUNDED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    age < (CW+1)'(MAX_WAIT)); // R5
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int DIV_W    = 5,
  parameter int MND_W    = 8,
  parameter int MAX_WAIT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             safe_pulse,
  input  logic             root_off_in,
  output logic             root_en,
  output logic [DIV_W-1:0] act_div,
  output logic [2:0]       act_src,
  output logic [1:0]       act_mode,
  output logic [MND_W-1:0] act_m,
  output logic [MND_W-1:0] act_n,
  output logic [MND_W-1:0] act_d
);
  localparam int CFG_W  = DIV_W + SRC_W + MODE_W;
  localparam int N_CTR  = 3;

  logic [2:0] word;
  logic       wr_cmd, wr_cfg;
  logic       req_set, pending, commit;
  logic [CFG_W-1:0] cfg_wval, cfg_sh, cfg_act;
  logic       cfg_dirty;
  logic [MND_W-1:0] ctr_sh  [N_CTR];
  logic [MND_W-1:0] ctr_act [N_CTR];
  logic [N_CTR-1:0] ctr_dirty;
  logic [N_CTR-1:0] ctr_wr;

  assign word    = bus_addr[4:2];
  assign wr_cmd  = bus_wr && (word == W_CMD);
  assign wr_cfg  = bus_wr && (word == W_CFG);
  assign req_set = wr_cmd && bus_wdata[CMD_UPD_BIT];

  assign cfg_wval = {bus_wdata[CFG_MODE_LSB +: MODE_W],
                     bus_wdata[CFG_SRC_LSB +: SRC_W],
                     bus_wdata[DIV_W-1:0]};

  clkcfg_commit_ctrl #(.MAX_WAIT(MAX_WAIT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_set    (req_set),
    .safe_pulse (safe_pulse),
    .pending    (pending),
    .commit     (commit)
  );

  clkcfg_field #(.W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_cfg),
    .wr_val   (cfg_wval),
    .commit   (commit),
    .shadow_q (cfg_sh),
    .active_q (cfg_act),
    .dirty_q  (cfg_dirty)
  );

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    localparam logic [2:0] MY_WORD = W_M + 3'(g);
    assign ctr_wr[g] = bus_wr && (word == MY_WORD);
    clkcfg_field #(.W(MND_W)) u_fld (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctr_wr[g]),
      .wr_val   (bus_wdata[MND_W-1:0]),
      .commit   (commit),
      .shadow_q (ctr_sh[g]),
      .active_q (ctr_act[g]),
      .dirty_q  (ctr_dirty[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      root_en <= 1'b1;
    else if (wr_cmd) root_en <= bus_wdata[CMD_EN_BIT];
  end

  assign act_div  = cfg_act[DIV_W-1:0];
  assign act_src  = cfg_act[DIV_W +: SRC_W];
  assign act_mode = cfg_act[DIV_W+SRC_W +: MODE_W];
  assign act_m    = ctr_act[CTR_M];
  assign act_n    = ctr_act[CTR_N];
  assign act_d    = ctr_act[CTR_D];

  always_comb begin
    bus_rdata = '0;
    unique case (word)
      W_CMD: begin
        bus_rdata[CMD_UPD_BIT]  = pending;
        bus_rdata[CMD_EN_BIT]   = root_en;
        bus_rdata[CMD_DCFG_BIT] = cfg_dirty;
        bus_rdata[CMD_DN_BIT]   = ctr_dirty[CTR_N];
        bus_rdata[CMD_DM_BIT]   = ctr_dirty[CTR_M];
        bus_rdata[CMD_DD_BIT]   = ctr_dirty[CTR_D];
        bus_rdata[CMD_OFF_BIT]  = root_off_in;
      end
      W_CFG: begin
        bus_rdata[DIV_W-1:0]                 = cfg_sh[DIV_W-1:0];
        bus_rdata[CFG_SRC_LSB +: SRC_W]      = cfg_sh[DIV_W +: SRC_W];
        bus_rdata[CFG_MODE_LSB +: MODE_W]    = cfg_sh[DIV_W+SRC_W +: MODE_W];
      end
      W_M:     bus_rdata[MND_W-1:0] = ctr_sh[CTR_M];
      W_N:     bus_rdata[MND_W-1:0] = ctr_sh[CTR_N];
      W_D:     bus_rdata[MND_W-1:0] = ctr_sh[CTR_D];
      default: bus_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  AST_OFF_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (word == W_CMD) |-> bus_rdata[CMD_OFF_BIT] == root_off_in); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (word > W_D) |-> bus_rdata == 32'd0); // R10
  AST_ROOT_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(root_en)); // R9
endmodule

// File: tb/clkcfg_regbank_tb.sv
module clkcfg_regbank_tb;
  localparam int DIV_W = 5;
  localparam int MND_W = 8;
  localparam int MAXW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        safe_pulse = 1'b0;
  logic        root_off_in = 1'b0;
  logic        root_en;
  logic [DIV_W-1:0] act_div;
  logic [2:0]  act_src;
  logic [1:0]  act_mode;
  logic [MND_W-1:0] act_m, act_n, act_d;

  always #5 clk = ~clk;

  clkcfg_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .safe_pulse(safe_pulse),
    .root_off_in(root_off_in), .root_en(root_en), .act_div(act_div),
    .act_src(act_src), .act_mode(act_mode), .act_m(act_m), .act_n(act_n),
    .act_d(act_d)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model (from the requirements)
  logic [9:0] m_sh_cfg, m_act_cfg;
  logic [7:0] m_sh [3];   // 0=M 1=N 2=D
  logic [7:0] m_act [3];
  logic [3:0] m_dirty;    // [0]=cfg [1]=N [2]=M [3]=D, i.e. command bits 7:4 in order
  logic       m_pend, m_en;
  int         m_wcnt;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sh_cfg = '0; m_act_cfg = '0; m_dirty = '0; m_pend = 0; m_en = 1; m_wcnt = 0;
    for (int i = 0; i < 3; i++) begin m_sh[i] = '0; m_act[i] = '0; end
  endtask

  task automatic model_edge(input bit wr, input logic [4:0] a, input logic [31:0] d, input bit safe);
    bit commit;
    bit req;
    logic [9:0] cv;
    logic [9:0] nact_cfg;
    logic [7:0] nact [3];
    int w;
    int ci;
    w = int'(a[4:2]);
    commit = m_pend && (safe || m_wcnt == MAXW - 1);
    nact_cfg = commit ? m_sh_cfg : m_act_cfg;
    for (int i = 0; i < 3; i++) nact[i] = commit ? m_sh[i] : m_act[i];
    req = wr && w == 0 && d[0];
    m_wcnt = (commit || !m_pend) ? 0 : m_wcnt + 1;
    m_pend = req ? 1'b1 : (commit ? 1'b0 : m_pend);
    if (commit) m_dirty = '0;
    if (wr) begin
      if (w == 0) m_en = d[1];
      if (w == 1) begin
        cv = {d[13:12], d[10:8], d[4:0]};
        m_sh_cfg = cv;
        if (cv != nact_cfg) m_dirty[0] = 1'b1;
      end
      if (w >= 2 && w <= 4) begin
        ci = w - 2;
        m_sh[ci] = d[7:0];
        if (d[7:0] != nact[ci]) m_dirty[ci == 0 ? 2 : (ci == 1 ? 1 : 3)] = 1'b1;
      end
    end
    m_act_cfg = nact_cfg;
    for (int i = 0; i < 3; i++) m_act[i] = nact[i];
  endtask

  function automatic logic [31:0] exp_read(input int w);
    logic [31:0] r;
    r = '0;
    case (w)
      0: begin r[0] = m_pend; r[1] = m_en; r[7:4] = m_dirty; r[31] = root_off_in; end
      1: begin r[4:0] = m_sh_cfg[4:0]; r[10:8] = m_sh_cfg[7:5]; r[13:12] = m_sh_cfg[9:8]; end
      2: r[7:0] = m_sh[0];
      3: r[7:0] = m_sh[1];
      4: r[7:0] = m_sh[2];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic step(input bit wr, input logic [4:0] a, input logic [31:0] d, input bit safe);
    bus_wr = wr; bus_addr = a; bus_wdata = d; safe_pulse = safe;
    @(posedge clk);
    model_edge(wr, a, d, safe);
    @(negedge clk);
    bus_wr = 1'b0; safe_pulse = 1'b0;
  endtask

  task automatic rd(input int w, input logic [1:0] lo, output logic [31:0] v);
    bus_addr = {3'(w), lo};
    #1;
    v = bus_rdata;
  endtask

  task automatic chk_outputs(input string req);
    chk({root_en, act_mode, act_src, act_div}, {m_en, m_act_cfg[9:8], m_act_cfg[7:5], m_act_cfg[4:0]}, req);
    chk({act_m, act_n, act_d}, {m_act[0], m_act[1], m_act[2]}, req);
  endtask

  task automatic chk_read(input int w, input string req);
    logic [31:0] v;
    rd(w, 2'b00, v);
    chk(v, exp_read(w), req);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 0, v); chk(v, 32'h0000_0002, "R1 cmd");
    for (int w = 1; w <= 4; w++) begin rd(w, 0, v); chk(v, 32'h0, "R1 regs"); end
    chk({31'd0, root_en}, 32'd1, "R1 root_en");
    chk({19'd0, act_mode, act_src, act_div, act_m}, 32'd0, "R1 active");

    // R7 cfg layout, R2 staged, R6 dirty
    step(1, 5'h04, 32'hFFFF_FFFF, 0);
    rd(1, 0, v); chk(v, 32'h0000_371F, "R7 cfg layout");
    rd(0, 0, v); chk(v, 32'h0000_0012, "R6 cfg dirty");
    chk({27'd0, act_div}, 32'd0, "R2 active unchanged");

    // R8 masking
    step(1, 5'h08, 32'hABCD_1234, 0);
    rd(2, 0, v); chk(v, 32'h0000_0034, "R8 M mask");
    // R6 equal value leaves N clean
    step(1, 5'h0C, 32'hFFFF_FF00, 0);
    rd(0, 0, v); chk(v, 32'h0000_0052, "R6 N equal clean");

    // R11 idle safe pulse
    step(0, 5'h00, 32'h0, 1);
    chk_outputs("R11 idle safe");
    rd(0, 0, v); chk(v, 32'h0000_0052, "R11 regs");

    // R3 set, and write of 0 does not clear
    step(1, 5'h00, 32'h0000_0003, 0);
    rd(0, 0, v); chk(v[0], 1'b1, "R3 update set");
    step(1, 5'h00, 32'h0000_0002, 0);
    rd(0, 0, v); chk(v[0], 1'b1, "R3 zero keeps");
    chk({27'd0, act_div}, 32'd0, "R2 before commit");

    // R4 commit on safe pulse
    step(0, 5'h00, 32'h0, 1);
    chk({act_mode, act_src, act_div}, {2'b11, 3'b111, 5'h1F}, "R4 cfg commit");
    chk({24'd0, act_m}, 32'h34, "R4 M commit");
    rd(0, 0, v); chk(v, 32'h0000_0002, "R4 update and dirty clear");

    // R5 forced commit
    step(1, 5'h10, 32'h0000_0055, 0);
    step(1, 5'h00, 32'h0000_0003, 0);
    for (int i = 0; i < MAXW - 1; i++) step(0, 5'h00, 32'h0, 0);
    rd(0, 0, v); chk(v[0], 1'b1, "R5 still pending");
    chk({24'd0, act_d}, 32'h0, "R5 not yet");
    step(0, 5'h00, 32'h0, 0);
    rd(0, 0, v); chk(v[0], 1'b0, "R5 forced commit");
    chk({24'd0, act_d}, 32'h55, "R5 D active");

    // R9 root enable and off status
    step(1, 5'h00, 32'h8000_0000, 0);
    chk({31'd0, root_en}, 32'd0, "R9 enable off");
    root_off_in = 1'b1;
    rd(0, 0, v); chk(v, 32'h8000_0000, "R9 off status");
    root_off_in = 1'b0;
    step(1, 5'h00, 32'h8000_0002, 0);
    rd(0, 0, v); chk(v, 32'h0000_0002, "R9 bit31 read only");

    // R10 unmapped, low address bits
    step(1, 5'h14, 32'hFFFF_FFFF, 0);
    step(1, 5'h1C, 32'hFFFF_FFFF, 0);
    rd(5, 0, v); chk(v, 32'h0, "R10 unmapped read");
    rd(7, 0, v); chk(v, 32'h0, "R10 unmapped read");
    for (int w = 0; w <= 4; w++) chk_read(w, "R10 no side effect");
    step(1, 5'h0B, 32'h0000_0077, 0);
    rd(2, 2'b11, v); chk(v, 32'h77, "R10 low addr bits");
    chk_outputs("R10 outputs");

    // random traffic against the model
    for (int it = 0; it < 3000; it++) begin
      bit wr;
      bit sp;
      int w;
      logic [31:0] d;
      wr = ($urandom % 8) < 5;
      w = int'($urandom % 8);
      d = $urandom;
      if (w == 0 && ($urandom % 2) == 0) d[0] = 1'b0;
      sp = ($urandom % 6) == 0;
      root_off_in = ($urandom % 4) == 0;
      step(wr, {3'(w), 2'($urandom % 4)}, d, sp);
      chk_outputs("R4 R5 random outputs");
      chk_read(int'($urandom % 8), "R2 R6 random read");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule